// File: doc/BRIEF.md
# Operand Effective Address Generator

This block works out the 32-bit memory address for a single operand specifier of a complex-instruction processor. A decoder hands it the addressing mode, a base selector, two displacements that are already sign-extended, an optional index (register number and scale), and the live register values. A one-cycle `start` pulse launches the calculation. The result comes back with a one-cycle `done` pulse. The result tells the consumer one of three things: the operand sits in a register, the operand is an immediate taken from the instruction stream, or the operand is at the address on `ea`.

Two modes need a pointer taken from memory. Double-indirect pointer-relative mode reads a pointer at disp1 plus FP, SP or SB. Link-table mode reads a pointer from entry disp1 of the module's link table. The block issues these 32-bit reads through a valid/ready request port and takes the data on a separate response strobe. It then adds disp2 to the pointer that came back.

Top-of-stack mode works on one of two stack pointers. It reports the new value of that pointer, so the register file can write it back in the same cycle as `done`.

Top module: `ea_gen`

## Requirements
- R1: After reset, `done`, `rd_valid` and `sp_we` are 0.
- R2: Register mode (code 0) completes one cycle after `start` with `kind`=0 (register), `ea`=0, and no memory request.
- R3: Immediate mode (code 4) completes one cycle after `start` with `kind`=1 (immediate) and `ea`=0.
- R4: Register-relative mode (code 1) yields disp1 plus general register R[`base_sel`], with `kind`=2 (memory), one cycle after `start`.
- R5: Absolute mode (code 5) yields disp1. Program-relative mode (code 7) yields disp1 plus PC.
- R6: Pointer-relative mode (code 6) yields disp1 plus FP, SP or SB, chosen by `base_sel` 0, 1 or 2. SP means SP1 when `stk_sel`=1 and SP0 otherwise.
- R7: Double-indirect mode (code 2) reads memory at disp1 plus the pointer chosen as in R6, then yields disp2 plus the returned word. The request address and valid stay steady until `rd_ready`.
- R8: Link-table mode (code 3) reads at `link_base` + 4*disp1, then yields disp2 plus the returned word.
- R9: With `idx_en`=1, R[`idx_reg`] shifted left by `idx_scale` (scale 0..3 gives factors 1, 2, 4, 8) is added to the address of any memory base mode. This includes the modes that fetch a pointer.
- R10: Top-of-stack pop (mode 8, `tos_push`=0) yields the selected stack pointer. It pulses `sp_we` with `done`, sets `sp_wsel`=`stk_sel`, and sets `sp_wdata` = pointer + (1<<`op_size`) bytes.
- R11: Top-of-stack push (mode 8, `tos_push`=1) yields pointer − (1<<`op_size`). It writes that same value back through `sp_wdata`.
- R12: An index on a register, immediate or top-of-stack base, or a mode code above 8, completes with `illegal`=1, `ea`=0, `sp_we`=0 and no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one calculation (sampled when idle) |
| mode | input | 4 | Addressing mode code |
| base_sel | input | 3 | Register number or pointer select |
| disp1 | input | 32 | First displacement |
| disp2 | input | 32 | Second displacement |
| idx_en | input | 1 | Apply index |
| idx_reg | input | 3 | Index register number |
| idx_scale | input | 2 | Index shift amount |
| stk_sel | input | 1 | Stack pointer select |
| tos_push | input | 1 | Top-of-stack direction: 1 push, 0 pop |
| op_size | input | 2 | Operand size, log2 of bytes |
| gpr_flat | input | 256 | R0..R7, R0 in the low bits |
| fp | input | 32 | Frame pointer |
| sp0 | input | 32 | Stack pointer 0 |
| sp1 | input | 32 | Stack pointer 1 |
| sb | input | 32 | Static base |
| pc | input | 32 | Program counter |
| link_base | input | 32 | Link table base of current module |
| rd_valid | output | 1 | Pointer read request |
| rd_addr | output | 32 | Pointer read address |
| rd_ready | input | 1 | Request accepted |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 32 | Read data |
| done | output | 1 | Result valid pulse |
| ea | output | 32 | Effective address |
| kind | output | 2 | 0 register, 1 immediate, 2 memory |
| illegal | output | 1 | Illegal mode combination |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wsel | output | 1 | Which stack pointer to write |
| sp_wdata | output | 32 | New stack pointer value |

## Verification
Two pairs of functions can land in the same cycle. In the first, the address report and the stack write-back share the `done` cycle. In the second, the illegal-index check meets a top-of-stack request. The bench issues top-of-stack pushes and pops on both stack pointers and reads `ea` and `sp_wdata` together in the `done` cycle. It then repeats a pop with an index enabled and judges that `illegal` rises while `sp_we` stays low. Index scaling also meets pointer-fetch completion, so indexed double-indirect requests check that the scaled index and disp2 both land on the fetched word.

// File: rtl/eag_pkg.sv
package eag_pkg;
    localparam int AW   = 32;
    localparam int NGPR = 8;
    localparam int RSW  = $clog2(NGPR);

    typedef enum logic [3:0] {
        AM_REG    = 4'd0,
        AM_REGREL = 4'd1,
        AM_MEMREL = 4'd2,
        AM_EXT    = 4'd3,
        AM_IMM    = 4'd4,
        AM_ABS    = 4'd5,
        AM_PTRREL = 4'd6,
        AM_PCREL  = 4'd7,
        AM_TOS    = 4'd8
    } am_e;

    typedef enum logic [1:0] {
        K_REG = 2'd0,
        K_IMM = 2'd1,
        K_MEM = 2'd2
    } kind_e;

    typedef struct packed {
        logic [AW-1:0] addr;      // final address or pointer-fetch address
        logic          fetch;     // needs a pointer read
        kind_e         kind;
        logic          illegal;
        logic          is_tos;
        logic [AW-1:0] sp_cur;
        logic [AW-1:0] sz_bytes;
    } base_res_t;

    function automatic logic [AW-1:0] size_bytes(input logic [1:0] code);
        return AW'(1) << code;
    endfunction
endpackage

// File: rtl/ea_base.sv
module ea_base
    import eag_pkg::*;
(
    input  logic [3:0]         mode,
    input  logic [RSW-1:0]     base_sel,
    input  logic [AW-1:0]      disp1,
    input  logic               idx_en,
    input  logic               stk_sel,
    input  logic               tos_push,
    input  logic [1:0]         op_size,
    input  logic [NGPR*AW-1:0] gpr_flat,
    input  logic [AW-1:0]      fp,
    input  logic [AW-1:0]      sp0,
    input  logic [AW-1:0]      sp1,
    input  logic [AW-1:0]      sb,
    input  logic [AW-1:0]      pc,
    input  logic [AW-1:0]      link_base,
    output base_res_t          res
);
    logic [AW-1:0] gpr [NGPR];
    logic [AW-1:0] ptr;
    logic [AW-1:0] spc;
    logic [AW-1:0] sz;

    for (genvar g = 0; g < NGPR; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*AW +: AW];
    end

    assign spc = stk_sel ? sp1 : sp0;
    assign sz  = size_bytes(op_size);

    always_comb begin
        case (base_sel[1:0])
            2'd0:    ptr = fp;
            2'd1:    ptr = spc;
            default: ptr = sb;
        endcase
    end

    always_comb begin
        res          = '0;
        res.kind     = K_MEM;
        res.sp_cur   = spc;
        res.sz_bytes = sz;
        case (mode)
            AM_REG:    res.kind = K_REG;
            AM_IMM:    res.kind = K_IMM;
            AM_REGREL: res.addr = disp1 + gpr[base_sel];
            AM_MEMREL: begin res.addr = disp1 + ptr; res.fetch = 1'b1; end
            AM_EXT:    begin res.addr = link_base + (disp1 << 2); res.fetch = 1'b1; end
            AM_ABS:    res.addr = disp1;
            AM_PTRREL: res.addr = disp1 + ptr;
            AM_PCREL:  res.addr = disp1 + pc;
            AM_TOS: begin
                res.is_tos = 1'b1;
                res.addr   = tos_push ? spc - sz : spc;
            end
            default:   res.illegal = 1'b1;
        endcase
        if (idx_en && (mode == AM_REG || mode == AM_IMM || mode == AM_TOS))
            res.illegal = 1'b1;
        if (res.illegal) begin
            res.fetch  = 1'b0;
            res.is_tos = 1'b0;
        end
    end
endmodule

// File: rtl/ea_index.sv
module ea_index
    import eag_pkg::*;
(
    input  logic               idx_en,
    input  logic [RSW-1:0]     idx_reg,
    input  logic [1:0]         idx_scale,
    input  logic [NGPR*AW-1:0] gpr_flat,
    output logic [AW-1:0]      idx_off
);
    logic [AW-1:0] rv;
    assign rv      = gpr_flat[idx_reg*AW +: AW];
    assign idx_off = idx_en ? (rv << idx_scale) : '0;
endmodule

// File: rtl/ea_ctrl.sv
module ea_ctrl
    import eag_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  base_res_t     br,
    input  logic [AW-1:0] idx_off,
    input  logic [AW-1:0] disp2,
    input  logic          tos_push,
    input  logic          stk_sel,
    input  logic          rd_ready,
    input  logic          rsp_valid,
    input  logic [AW-1:0] rsp_data,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic          done,
    output logic [AW-1:0] ea,
    output logic [1:0]    kind,
    output logic          illegal,
    output logic          sp_we,
    output logic          sp_wsel,
    output logic [AW-1:0] sp_wdata
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT, S_DONE} st_e;
    st_e           st;
    logic [AW-1:0] tail;   // disp2 plus scaled index, added to fetched pointer
    logic          sp_pend;

    assign rd_valid = (st == S_REQ);
    assign done     = (st == S_DONE);
    assign sp_we    = done && sp_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            rd_addr  <= '0;
            ea       <= '0;
            kind     <= '0;
            illegal  <= 1'b0;
            tail     <= '0;
            sp_pend  <= 1'b0;
            sp_wsel  <= 1'b0;
            sp_wdata <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    kind    <= br.kind;
                    illegal <= br.illegal;
                    sp_pend <= br.is_tos;
                    sp_wsel <= stk_sel;
                    sp_wdata <= tos_push ? br.addr : br.sp_cur + br.sz_bytes;
                    if (br.illegal) begin
                        ea <= '0;
                        st <= S_DONE;
                    end else if (br.fetch) begin
                        rd_addr <= br.addr;
                        tail    <= disp2 + idx_off;
                        st      <= S_REQ;
                    end else begin
                        ea <= (br.kind == K_MEM) ? br.addr + idx_off : '0;
                        st <= S_DONE;
                    end
                end
                S_REQ:  if (rd_ready)  st <= S_WAIT;
                S_WAIT: if (rsp_valid) begin
                    ea <= tail + rsp_data;
                    st <= S_DONE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    a_r7_req_hold: assert property (@(posedge clk) disable iff (rst)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));
    a_r12_no_update_on_illegal: assert property (@(posedge clk) disable iff (rst)
        done && illegal |-> !sp_we);
    a_r10_sp_we_with_done: assert property (@(posedge clk) disable iff (rst)
        sp_we |-> done);
    a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r7_no_req_at_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !rd_valid);
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import eag_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [3:0]         mode,
    input  logic [2:0]         base_sel,
    input  logic [31:0]        disp1,
    input  logic [31:0]        disp2,
    input  logic               idx_en,
    input  logic [2:0]         idx_reg,
    input  logic [1:0]         idx_scale,
    input  logic               stk_sel,
    input  logic               tos_push,
    input  logic [1:0]         op_size,
    input  logic [255:0]       gpr_flat,
    input  logic [31:0]        fp,
    input  logic [31:0]        sp0,
    input  logic [31:0]        sp1,
    input  logic [31:0]        sb,
    input  logic [31:0]        pc,
    input  logic [31:0]        link_base,
    output logic               rd_valid,
    output logic [31:0]        rd_addr,
    input  logic               rd_ready,
    input  logic               rsp_valid,
    input  logic [31:0]        rsp_data,
    output logic               done,
    output logic [31:0]        ea,
    output logic [1:0]         kind,
    output logic               illegal,
    output logic               sp_we,
    output logic               sp_wsel,
    output logic [31:0]        sp_wdata
);
    base_res_t     br;
    logic [AW-1:0] idx_off;

    ea_base u_base (
        .mode(mode), .base_sel(base_sel), .disp1(disp1), .idx_en(idx_en),
        .stk_sel(stk_sel), .tos_push(tos_push), .op_size(op_size),
        .gpr_flat(gpr_flat), .fp(fp), .sp0(sp0), .sp1(sp1), .sb(sb),
        .pc(pc), .link_base(link_base), .res(br)
    );

    ea_index u_index (
        .idx_en(idx_en), .idx_reg(idx_reg), .idx_scale(idx_scale),
        .gpr_flat(gpr_flat), .idx_off(idx_off)
    );

    ea_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .br(br), .idx_off(idx_off),
        .disp2(disp2), .tos_push(tos_push), .stk_sel(stk_sel),
        .rd_ready(rd_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .done(done), .ea(ea),
        .kind(kind), .illegal(illegal), .sp_we(sp_we), .sp_wsel(sp_wsel),
        .sp_wdata(sp_wdata)
    );
endmodule

// File: tb/tb_ea_gen.sv
module tb_ea_gen;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;   // 250 MHz

    logic        start = 0;
    logic [3:0]  mode = 0;
    logic [2:0]  base_sel = 0;
    logic [31:0] disp1 = 0, disp2 = 0;
    logic        idx_en = 0;
    logic [2:0]  idx_reg = 0;
    logic [1:0]  idx_scale = 0;
    logic        stk_sel = 0, tos_push = 0;
    logic [1:0]  op_size = 0;
    logic [255:0] gpr_flat;
    logic [31:0] fp = 32'h2000, sp0 = 32'h3000, sp1 = 32'h4000;
    logic [31:0] sb = 32'h5000, pc = 32'h6000, link_base = 32'h7000;
    logic        rd_ready = 0, rsp_valid = 0;
    logic [31:0] rsp_data = 0;
    logic        rd_valid, done, illegal, sp_we, sp_wsel;
    logic [31:0] rd_addr, ea, sp_wdata;
    logic [1:0]  kind;

    ea_gen dut (.*);

    int n_chk = 0, n_fail = 0;
    logic [31:0] mem_word;
    int          c_done, c_nreq, c_stable;
    logic [31:0] c_ea, c_raddr, c_wdata;
    logic [1:0]  c_kind;
    logic        c_ill, c_we, c_wsel;

    function automatic logic [31:0] gv(input int i);
        return 32'h1000_0000 + 32'(i) * 32'h111;
    endfunction

    initial for (int i = 0; i < 8; i++) gpr_flat[i*32 +: 32] = gv(i);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // launch one request, act as memory with one stall cycle, capture result
    task automatic issue(input logic [3:0] m, input logic [2:0] bs,
                         input logic [31:0] d1, input logic [31:0] d2,
                         input logic ie, input logic [2:0] ir, input logic [1:0] sc);
        int  stall = 1;
        logic pend = 0;
        mode = m; base_sel = bs; disp1 = d1; disp2 = d2;
        idx_en = ie; idx_reg = ir; idx_scale = sc;
        c_done = 0; c_nreq = 0; c_stable = 1; c_raddr = 0;
        start = 1;
        @(negedge clk);
        start = 0;
        for (int i = 0; i < 20; i++) begin
            rd_ready = 0; rsp_valid = 0;
            if (done) begin
                c_done = 1; c_ea = ea; c_kind = kind; c_ill = illegal;
                c_we = sp_we; c_wsel = sp_wsel; c_wdata = sp_wdata;
                break;
            end
            if (pend) begin
                rsp_valid = 1; rsp_data = mem_word; pend = 0;
            end else if (rd_valid) begin
                if (c_nreq > 0 && rd_addr !== c_raddr) c_stable = 0;
                c_raddr = rd_addr;
                c_nreq++;
                if (stall > 0) stall--;
                else begin rd_ready = 1; pend = 1; end
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 done", {31'b0, done}, 0);
        chk("R1 rd_valid", {31'b0, rd_valid}, 0);
        chk("R1 sp_we", {31'b0, sp_we}, 0);
    endtask

    task automatic t_reg_imm;
        issue(4'd0, 3'd2, 0, 0, 0, 0, 0);
        chk("R2 kind", {30'b0, c_kind}, 0);
        chk("R2 ea", c_ea, 0);
        chk("R2 nreq", 32'(c_nreq), 0);
        issue(4'd4, 3'd0, 32'h55, 0, 0, 0, 0);
        chk("R3 kind", {30'b0, c_kind}, 1);
        chk("R3 ea", c_ea, 0);
    endtask

    task automatic t_direct;
        issue(4'd1, 3'd5, 32'h10, 0, 0, 0, 0);
        chk("R4 ea", c_ea, gv(5) + 32'h10);
        chk("R4 kind", {30'b0, c_kind}, 2);
        issue(4'd1, 3'd7, 32'hFFFF_FFFC, 0, 0, 0, 0);
        chk("R4 neg disp", c_ea, gv(7) - 4);
        issue(4'd5, 3'd0, 32'h1234_5678, 0, 0, 0, 0);
        chk("R5 abs", c_ea, 32'h1234_5678);
        issue(4'd7, 3'd0, 32'h20, 0, 0, 0, 0);
        chk("R5 pcrel", c_ea, 32'h6020);
    endtask

    task automatic t_ptrrel;
        issue(4'd6, 3'd0, 32'h8, 0, 0, 0, 0);
        chk("R6 fp", c_ea, 32'h2008);
        stk_sel = 1;
        issue(4'd6, 3'd1, 32'h8, 0, 0, 0, 0);
        chk("R6 sp1", c_ea, 32'h4008);
        stk_sel = 0;
        issue(4'd6, 3'd1, 32'h8, 0, 0, 0, 0);
        chk("R6 sp0", c_ea, 32'h3008);
        issue(4'd6, 3'd2, 32'h8, 0, 0, 0, 0);
        chk("R6 sb", c_ea, 32'h5008);
    endtask

    task automatic t_fetch;
        mem_word = 32'h8000_0000;
        issue(4'd2, 3'd2, 32'h40, 32'h6, 0, 0, 0);
        chk("R7 raddr", c_raddr, 32'h5040);
        chk("R7 stable", 32'(c_stable), 1);
        chk("R7 ea", c_ea, 32'h8000_0006);
        chk("R7 done", 32'(c_done), 1);
        mem_word = 32'h0009_0000;
        issue(4'd3, 3'd0, 32'h3, 32'h10, 0, 0, 0);
        chk("R8 raddr", c_raddr, 32'h700C);
        chk("R8 ea", c_ea, 32'h0009_0010);
    endtask

    task automatic t_index;
        issue(4'd5, 3'd0, 32'h100, 0, 1, 3'd1, 2'd0);
        chk("R9 x1", c_ea, 32'h100 + gv(1));
        issue(4'd5, 3'd0, 32'h100, 0, 1, 3'd1, 2'd1);
        chk("R9 x2", c_ea, 32'h100 + 2 * gv(1));
        issue(4'd6, 3'd0, 32'h0, 0, 1, 3'd2, 2'd2);
        chk("R9 x4", c_ea, 32'h2000 + 4 * gv(2));
        mem_word = 32'h00A0_0000;
        issue(4'd2, 3'd0, 32'h4, 32'h2, 1, 3'd3, 2'd3);
        chk("R9 fetch raddr", c_raddr, 32'h2004);
        chk("R9 x8 fetch", c_ea, 32'h00A0_0002 + 8 * gv(3));
    endtask

    task automatic t_tos;
        stk_sel = 0; tos_push = 0; op_size = 2;
        issue(4'd8, 3'd0, 0, 0, 0, 0, 0);
        chk("R10 ea", c_ea, 32'h3000);
        chk("R10 we", {31'b0, c_we}, 1);
        chk("R10 wsel", {31'b0, c_wsel}, 0);
        chk("R10 wdata", c_wdata, 32'h3004);
        stk_sel = 1; tos_push = 1; op_size = 3;
        issue(4'd8, 3'd0, 0, 0, 0, 0, 0);
        chk("R11 ea", c_ea, 32'h3FF8);
        chk("R11 we", {31'b0, c_we}, 1);
        chk("R11 wsel", {31'b0, c_wsel}, 1);
        chk("R11 wdata", c_wdata, 32'h3FF8);
        stk_sel = 0; tos_push = 0; op_size = 0;
    endtask

    task automatic t_illegal;
        issue(4'd8, 3'd0, 0, 0, 1, 3'd1, 0);
        chk("R12 tos ill", {31'b0, c_ill}, 1);
        chk("R12 tos we", {31'b0, c_we}, 0);
        chk("R12 tos ea", c_ea, 0);
        issue(4'd0, 3'd0, 0, 0, 1, 3'd1, 0);
        chk("R12 reg ill", {31'b0, c_ill}, 1);
        issue(4'd4, 3'd0, 0, 0, 1, 3'd1, 0);
        chk("R12 imm ill", {31'b0, c_ill}, 1);
        issue(4'd12, 3'd0, 32'h40, 0, 0, 0, 0);
        chk("R12 bad code", {31'b0, c_ill}, 1);
        chk("R12 bad nreq", 32'(c_nreq), 0);
        issue(4'd5, 3'd0, 32'h40, 0, 0, 0, 0);
        chk("R12 legal clear", {31'b0, c_ill}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        @(negedge clk);
        t_reg_imm();
        t_direct();
        t_ptrrel();
        t_fetch();
        t_index();
        t_tos();
        t_illegal();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #100000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule